// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the write-cycle detector and the page load sequencer of a byte-alterable non-volatile memory. Every byte load is passed through a command matcher. The matcher recognises two fixed command sequences on the address and data lines. The block then tells the page sequencer whether each load may be stored. It also marks the loads that are command bytes, so that they are never written into the array.

A persistent protect bit models the non-volatile protection mode. The power-on reset input clears the matcher but leaves this bit alone. The bit starts cleared. A three-byte unlock sequence sets the bit and opens one page-load window for at most `PAGE_BYTES` data bytes. After that page has been programmed, the block is protected again. A six-byte clear sequence, followed by its programming cycle, returns the memory to unprotected operation. While the memory is unprotected, ordinary writes pass freely.

The states are as follows:
- `ST_IDLE`: no sequence is in progress.
- `ST_ARM1`, `ST_ARM2`: the first and second command bytes have matched.
- `ST_ARM3`, `ST_ARM4`, `ST_ARM5`: the third, fourth and fifth bytes of the clear sequence have matched.
- `ST_OPEN`: the page-load window is open.
- `ST_BURN`: waiting for programming of the window's page.
- `ST_CLRW`: waiting for the programming time that ends the clear sequence.

The transitions are as follows:
- `ST_IDLE`→`ST_ARM1` on AA at 5555.
- `ST_ARM1`→`ST_ARM2` on 55 at 2AAA.
- `ST_ARM2`→`ST_OPEN` on A0 at 5555. This transition also sets the protect bit.
- `ST_ARM2`→`ST_ARM3` on 80 at 5555.
- `ST_ARM3`→`ST_ARM4` on AA at 5555.
- `ST_ARM4`→`ST_ARM5` on 55 at 2AAA.
- `ST_ARM5`→`ST_CLRW` on 20 at 5555.
- Any `ST_ARMn`→`ST_IDLE` on a wrong byte or on a load timeout.
- `ST_OPEN`→`ST_BURN` on the last allowed byte, or on a timeout after at least one byte.
- `ST_OPEN`→`ST_IDLE` on a timeout before any byte.
- `ST_BURN`→`ST_IDLE` on `prog_done`.
- `ST_CLRW`→`ST_IDLE` on `prog_done`. This transition also clears the protect bit.

Top module: `swp_seq`

## Requirements
- R1: After power-up the protect bit is clear (`prot_on`=0). A load in this state gives `wr_allow`=1 and `cmd_byte`=0 in the same cycle.
- R2: The unlock sequence is AA at 15'h5555, then 55 at 15'h2AAA, then A0 at 15'h5555. Completing it sets `prot_on` from the next clock edge. The A0 load always gives `cmd_byte`=1 and `wr_allow`=0. When the block is protected, all three bytes give `cmd_byte`=1 and `wr_allow`=0.
- R3: When the block is unprotected, a load that matches a command prefix is passed through as a normal write (`wr_allow`=1, `cmd_byte`=0). Only the completing byte of a sequence (A0 or 20) is flagged as a command.
- R4: After the unlock sequence, up to `PAGE_BYTES` loads give `wr_allow`=1. The `PAGE_BYTES`-th load closes the window. Further loads give `wr_allow`=0 and `cmd_byte`=0 until `prog_done`.
- R5: A load timeout after at least one window byte closes the window. After `prog_done`, the block is protected and idle. Ordinary loads then give `wr_allow`=0 and `cmd_byte`=0.
- R6: When the block is protected, a load that does not match the next expected command byte writes nothing and is not flagged. The matcher returns to idle, so a later correct tail of the sequence does not unlock.
- R7: A load timeout while a sequence is partly matched returns the matcher to idle.
- R8: The clear sequence is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. The 20 byte gives `cmd_byte`=1. Loads are neither written nor flagged until `prog_done`. After `prog_done`, `prot_on`=0 and loads write normally.
- R9: The power-on reset `rst_n` does not change `prot_on`. It discards a partly matched sequence.
- R10: The matcher compares all 15 address bits. A0 at 15'h1555 does not complete the unlock sequence.
- R11: A load timeout in the open window before any data byte returns to idle. No `prog_done` is needed before the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; clears the matcher, not the protect bit |
| load_valid | input | 1 | One-cycle byte-load event |
| load_addr | input | ADDR_W | Address of the byte load |
| load_data | input | DATA_W | Data of the byte load |
| load_timeout | input | 1 | Byte-load window expired since the previous load |
| prog_done | input | 1 | Programming cycle finished |
| wr_allow | output | 1 | Current load may be stored by the page sequencer |
| cmd_byte | output | 1 | Current load is a command byte and must not be stored |
| prot_on | output | 1 | Persistent protection mode |

## Verification
Some properties are checked by the assertions on every cycle:
- `wr_allow` and `cmd_byte` are never high together.
- Neither output is high without a load.
- The protect bit rises only right after an A0 load at 5555, and falls only right after `prog_done`.
- An unprotected block flags only completing bytes.

Other behaviour is shown only by the directed scenarios, because it depends on the whole history of loads:
- the order-dependent sequence matching;
- the 64-byte window limit;
- the effect of timeouts;
- the persistence of the protect bit across reset.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_ARM1 = 4'd1,
        ST_ARM2 = 4'd2,
        ST_ARM3 = 4'd3,
        ST_ARM4 = 4'd4,
        ST_ARM5 = 4'd5,
        ST_OPEN = 4'd6,
        ST_BURN = 4'd7,
        ST_CLRW = 4'd8
    } swp_state_e;

    typedef struct packed {
        logic aa_lo;   // AA at 5555
        logic h55_hi;  // 55 at 2AAA
        logic a0_lo;   // A0 at 5555
        logic h80_lo;  // 80 at 5555
        logic h20_lo;  // 20 at 5555
    } swp_hit_t;

    localparam logic [14:0] CMD_ADR_LO = 15'h5555;
    localparam logic [14:0] CMD_ADR_HI = 15'h2AAA;
    localparam logic [7:0]  CMD_KEY1   = 8'hAA;
    localparam logic [7:0]  CMD_KEY2   = 8'h55;
    localparam logic [7:0]  CMD_OPEN   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_CLEAR  = 8'h20;

endpackage

// File: rtl/swp_cmd_match.sv
module swp_cmd_match
    import swp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output swp_hit_t          hit
);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CMD_ADR_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CMD_ADR_HI);

    logic at_lo;
    logic at_hi;

    assign at_lo = (addr == A_LO);
    assign at_hi = (addr == A_HI);

    always_comb begin
        hit        = '0;
        hit.aa_lo  = at_lo && (data == DATA_W'(CMD_KEY1));
        hit.h55_hi = at_hi && (data == DATA_W'(CMD_KEY2));
        hit.a0_lo  = at_lo && (data == DATA_W'(CMD_OPEN));
        hit.h80_lo = at_lo && (data == DATA_W'(CMD_ERASE));
        hit.h20_lo = at_lo && (data == DATA_W'(CMD_CLEAR));
    end

endmodule

// File: rtl/swp_win_count.sv
module swp_win_count #(
    parameter int PAGE_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last,
    output logic any
);
    localparam int CW = $clog2(PAGE_BYTES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = (cnt_q == CW'(PAGE_BYTES - 1));
    assign any  = (cnt_q != '0);

endmodule

// File: rtl/swp_keep_bit.sv
module swp_keep_bit (
    input  logic clk,
    input  logic set,
    input  logic clr,
    output logic q
);
    // No reset input: the value survives the power-on reset.
    logic q_r = 1'b0;

    always_ff @(posedge clk) begin
        if (clr) begin
            q_r <= 1'b0;
        end else if (set) begin
            q_r <= 1'b1;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/swp_seq.sv
module swp_seq
    import swp_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_timeout,
    input  logic              prog_done,
    output logic              wr_allow,
    output logic              cmd_byte,
    output logic              prot_on
);
    swp_state_e st_q;
    swp_state_e st_d;
    swp_hit_t   hit;
    logic       step_hit;
    logic       step_done;
    logic       set_prot;
    logic       clr_prot;
    logic       win_clr;
    logic       win_inc;
    logic       win_last;
    logic       win_any;

    swp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr (load_addr),
        .data (load_data),
        .hit  (hit)
    );

    swp_win_count #(.PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .inc   (win_inc),
        .last  (win_last),
        .any   (win_any)
    );

    swp_keep_bit u_keep (
        .clk (clk),
        .set (set_prot),
        .clr (clr_prot),
        .q   (prot_on)
    );

    // Does the current load extend (step_hit) or complete (step_done) a sequence?
    always_comb begin
        step_hit  = 1'b0;
        step_done = 1'b0;
        unique case (st_q)
            ST_IDLE: step_hit = hit.aa_lo;
            ST_ARM1: step_hit = hit.h55_hi;
            ST_ARM2: begin
                step_hit  = hit.h80_lo;
                step_done = hit.a0_lo;
            end
            ST_ARM3: step_hit = hit.aa_lo;
            ST_ARM4: step_hit = hit.h55_hi;
            ST_ARM5: step_done = hit.h20_lo;
            default: begin
                step_hit  = 1'b0;
                step_done = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and side effects
    always_comb begin
        st_d     = st_q;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        win_clr  = 1'b0;
        win_inc  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (load_valid && step_hit) st_d = ST_ARM1;
            end
            ST_ARM1, ST_ARM3, ST_ARM4: begin
                if (load_valid) begin
                    if (step_hit) begin
                        st_d = (st_q == ST_ARM1) ? ST_ARM2 :
                               (st_q == ST_ARM3) ? ST_ARM4 : ST_ARM5;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (load_timeout) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ARM2: begin
                if (load_valid) begin
                    if (step_done) begin
                        st_d     = ST_OPEN;
                        set_prot = 1'b1;
                        win_clr  = 1'b1;
                    end else if (step_hit) begin
                        st_d = ST_ARM3;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (load_timeout) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ARM5: begin
                if (load_valid) begin
                    st_d = step_done ? ST_CLRW : ST_IDLE;
                end else if (load_timeout) begin
                    st_d = ST_IDLE;
                end
            end
            ST_OPEN: begin
                if (load_valid) begin
                    win_inc = 1'b1;
                    if (win_last) st_d = ST_BURN;
                end else if (load_timeout) begin
                    st_d = win_any ? ST_BURN : ST_IDLE;
                end
            end
            ST_BURN: begin
                if (prog_done) st_d = ST_IDLE;
            end
            ST_CLRW: begin
                if (prog_done) begin
                    clr_prot = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Per-load outputs
    always_comb begin
        wr_allow = 1'b0;
        cmd_byte = 1'b0;
        if (load_valid) begin
            unique case (st_q)
                ST_IDLE, ST_ARM1, ST_ARM2, ST_ARM3, ST_ARM4, ST_ARM5: begin
                    cmd_byte = step_done || (prot_on && step_hit);
                    wr_allow = !prot_on && !step_done;
                end
                ST_OPEN: wr_allow = 1'b1;
                default: begin
                    wr_allow = 1'b0;
                    cmd_byte = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/swp_seq_chk.sv
module swp_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_valid,
    input logic [ADDR_W-1:0] load_addr,
    input logic [DATA_W-1:0] load_data,
    input logic              prog_done,
    input logic              wr_allow,
    input logic              cmd_byte,
    input logic              prot_on
);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(15'h5555);

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && cmd_byte));

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (!wr_allow && !cmd_byte));

    p_set_only_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(load_valid && load_addr == A_LO && load_data == DATA_W'(8'hA0)));

    p_clear_after_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(prog_done));

    p_unprot_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_byte && !prot_on) |-> (load_data == DATA_W'(8'hA0) || load_data == DATA_W'(8'h20)));

endmodule

bind swp_seq swp_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .prog_done  (prog_done),
    .wr_allow   (wr_allow),
    .cmd_byte   (cmd_byte),
    .prot_on    (prot_on)
);

// File: tb/test_swp_seq.sv
module test_swp_seq;
    localparam int CLK_PER = 10;
    localparam int PAGE    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [14:0] load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        load_timeout = 1'b0;
    logic        prog_done = 1'b0;
    logic        wr_allow;
    logic        cmd_byte;
    logic        prot_on;

    int total = 0;
    int bad   = 0;

    always #(CLK_PER/2) clk = ~clk;

    swp_seq #(.ADDR_W(15), .DATA_W(8), .PAGE_BYTES(PAGE)) i_swp_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_valid   (load_valid),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .load_timeout (load_timeout),
        .prog_done    (prog_done),
        .wr_allow     (wr_allow),
        .cmd_byte     (cmd_byte),
        .prot_on      (prot_on)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load(input logic [14:0] a, input logic [7:0] d,
                        input logic ew, input logic ec, input string req);
        @(negedge clk);
        load_valid = 1'b1;
        load_addr  = a;
        load_data  = d;
        #2;
        check(req, {wr_allow, cmd_byte}, {ew, ec});
        @(posedge clk);
        #1;
        load_valid = 1'b0;
    endtask

    task automatic pulse_tmo();
        @(negedge clk);
        load_timeout = 1'b1;
        @(posedge clk);
        #1;
        load_timeout = 1'b0;
    endtask

    task automatic pulse_prog();
        @(negedge clk);
        prog_done = 1'b1;
        @(posedge clk);
        #1;
        prog_done = 1'b0;
    endtask

    task automatic check_prot(input logic exp, input string req);
        check(req, {1'b0, prot_on}, {1'b0, exp});
    endtask

    task automatic t_reset();
        check_prot(1'b0, "R1 prot after power-up");
        load(15'h0123, 8'h5A, 1'b1, 1'b0, "R1 plain write");
    endtask

    task automatic t_prefix_unprot();
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R3 AA prefix written");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R3 55 prefix written");
        load(15'h0100, 8'h33, 1'b1, 1'b0, "R3 broken prefix written");
        check_prot(1'b0, "R3 still unprotected");
        pulse_tmo();
    endtask

    task automatic t_addr_full();
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R10 AA");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R10 55");
        load(15'h1555, 8'hA0, 1'b1, 1'b0, "R10 A0 at 1555 not command");
        check_prot(1'b0, "R10 no unlock");
    endtask

    task automatic t_unlock_window();
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R2 AA unprot");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R2 55 unprot");
        load(15'h5555, 8'hA0, 1'b0, 1'b1, "R2 A0 is command");
        check_prot(1'b1, "R2 protect set");
        for (int i = 0; i < 3; i++) load(15'h0200 + 15'(i), 8'(i), 1'b1, 1'b0, "R4 window byte");
        pulse_tmo();
        load(15'h0203, 8'h11, 1'b0, 1'b0, "R5 load during programming");
        pulse_prog();
        load(15'h0300, 8'h22, 1'b0, 1'b0, "R5 protected after page");
        check_prot(1'b1, "R5 protect kept");
    endtask

    task automatic t_full_page();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R2 AA prot");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R2 55 prot");
        load(15'h5555, 8'hA0, 1'b0, 1'b1, "R2 A0 prot");
        for (int i = 0; i < PAGE; i++) load(15'h0400 + 15'(i), 8'(i), 1'b1, 1'b0, "R4 page byte");
        load(15'h0440, 8'h77, 1'b0, 1'b0, "R4 byte past page");
        pulse_prog();
        load(15'h0441, 8'h78, 1'b0, 1'b0, "R5 after full page");
    endtask

    task automatic t_mismatch_prot();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R6 AA");
        load(15'h0040, 8'h12, 1'b0, 1'b0, "R6 wrong byte dropped");
        load(15'h2AAA, 8'h55, 1'b0, 1'b0, "R6 matcher idle");
        load(15'h5555, 8'hA0, 1'b0, 1'b0, "R6 no unlock");
        load(15'h0041, 8'h13, 1'b0, 1'b0, "R6 no window");
        check_prot(1'b1, "R6 still protected");
    endtask

    task automatic t_timeout();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R7 AA");
        pulse_tmo();
        load(15'h2AAA, 8'h55, 1'b0, 1'b0, "R7 sequence dropped");
    endtask

    task automatic t_empty_window();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R11 AA");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R11 55");
        load(15'h5555, 8'hA0, 1'b0, 1'b1, "R11 A0");
        pulse_tmo();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R11 idle without prog_done");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R11 55 again");
        load(15'h5555, 8'hA0, 1'b0, 1'b1, "R11 A0 again");
        load(15'h0500, 8'h44, 1'b1, 1'b0, "R11 window reopened");
        pulse_tmo();
        pulse_prog();
    endtask

    task automatic t_reset_keeps();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R9 AA");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R9 55");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_prot(1'b1, "R9 protect survives reset");
        load(15'h5555, 8'hA0, 1'b0, 1'b0, "R9 partial sequence gone");
    endtask

    task automatic t_disable();
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 AA");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R8 55");
        load(15'h5555, 8'h80, 1'b0, 1'b1, "R8 80");
        load(15'h5555, 8'hAA, 1'b0, 1'b1, "R8 AA 2");
        load(15'h2AAA, 8'h55, 1'b0, 1'b1, "R8 55 2");
        load(15'h5555, 8'h20, 1'b0, 1'b1, "R8 20");
        check_prot(1'b1, "R8 on until programmed");
        load(15'h0600, 8'h66, 1'b0, 1'b0, "R8 load while clearing");
        pulse_prog();
        check_prot(1'b0, "R8 protect cleared");
        load(15'h0601, 8'h67, 1'b1, 1'b0, "R8 normal write");
    endtask

    task automatic t_disable_unprot();
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R3 AA");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R3 55");
        load(15'h5555, 8'h80, 1'b1, 1'b0, "R3 80");
        load(15'h5555, 8'hAA, 1'b1, 1'b0, "R3 AA 2");
        load(15'h2AAA, 8'h55, 1'b1, 1'b0, "R3 55 2");
        load(15'h5555, 8'h20, 1'b0, 1'b1, "R8 20 unprot");
        pulse_prog();
        check_prot(1'b0, "R8 stays clear");
        load(15'h0700, 8'h01, 1'b1, 1'b0, "R8 write after clear");
    endtask

    initial begin
        #(CLK_PER * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_prefix_unprot();
        t_addr_full();
        t_unlock_window();
        t_full_page();
        t_mismatch_prot();
        t_timeout();
        t_empty_window();
        t_reset_keeps();
        t_disable();
        t_disable_unprot();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule